// File: doc/BRIEF.md
# Segment-Based Address Translation Front End

This block sits in front of a page-lookup unit and decides, for every 32-bit virtual address it accepts, whether the physical address can be formed at once or has to be fetched from page tables. Accepted requests carry an access kind and a user/kernel flag. When translation is switched off, the address passes through unchanged with read, write and execute all granted. When translation is on and a kernel access falls into a 256 MB segment whose bit is set in the segment map, the top physical nibble is taken from a packed table of sixteen 4-bit bases held in two base registers. The low 28 address bits are kept, and the access cannot miss.

Every other access is handed to the page-lookup unit over a request handshake. The unit's answer (address, permission bits, miss flag) is forwarded on the response channel. Four configuration words load from a plain write-enable port: a global control word, the segment map, and the low and high base registers. All four reset to zero.

The request and response channels are valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when nothing is in flight, so one transaction is handled at a time. A response stays valid with stable contents until `rsp_ready` is seen high at an edge. The lookup request `lk_valid` likewise holds its fields until `lk_ready` is seen. The lookup unit must raise `lk_done` for one cycle, at least one cycle after its `lk_ready`. Permission bits are read = bit 0, write = bit 1, execute = bit 2.

Top module: `seg_xlate_front`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `lk_valid` are 0, and all four configuration words are zero, so translation is off and no segment is mapped.
- R2: Translation is on only when bit 2 or bit 3 of the global control word is set. While it is off, an accepted request gives `rsp_valid` in the next cycle with `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b111 and `rsp_miss` = 0, whatever the segment map holds.
- R3: The segment number is virtual address bits [31:28]. With translation on, a kernel request (`req_user` = 0) to a segment whose bit in the segment map is set gives `rsp_valid` in the next cycle. The response has `rsp_paddr` = {base nibble, vaddr[27:0]}, `rsp_perm` = 3'b111 and `rsp_miss` = 0.
- R4: For segments 0 to 7 the base nibble is bits [4k+3:4k] of the low base register, and for segments 8 to 15 it is bits [4k+3:4k] of the high base register, where k is the segment number mod 8.
- R5: With translation on, a user request (`req_user` = 1) always goes to the page-lookup unit, even if its segment is mapped.
- R6: A request needing lookup raises `lk_valid` in the cycle after acceptance, carrying `lk_vaddr`, `lk_kind`, `lk_user` and `lk_inst`. These are held unchanged until an edge with `lk_ready` high, after which `lk_valid` falls.
- R7: When `lk_done` is seen high while waiting, the next cycle shows `rsp_valid` with `rsp_paddr`, `rsp_perm` and `rsp_miss` equal to `lk_paddr`, `lk_perm` and `lk_miss`.
- R8: The access kind codes are 0 = read, 1 = write, 2 = execute. Code 3 is handled as a read. `lk_inst` and `rsp_inst` are 1 only for execute, selecting the instruction path. `lk_kind` carries the code, with 3 replaced by 0.
- R9: While `rsp_valid` is high and `rsp_ready` low, all response fields hold. `req_ready` stays 0 from acceptance until the response is taken.
- R10: An edge with `cfg_we` high loads `cfg_wdata` into the word chosen by `cfg_sel`: 0 = global control, 1 = segment map (bit N for segment N), 2 = low base register, 3 = high base register. The next accepted request uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 read) |
| req_user | input | 1 | 1 = user access, 0 = kernel access |
| lk_valid | output | 1 | Page-lookup request valid |
| lk_ready | input | 1 | Page-lookup unit accepts request |
| lk_vaddr | output | 32 | Address to look up |
| lk_kind | output | 2 | Normalised access kind |
| lk_user | output | 1 | User flag to the lookup unit |
| lk_inst | output | 1 | 1 = instruction path, 0 = data path |
| lk_done | input | 1 | Lookup result strobe |
| lk_paddr | input | 32 | Looked-up physical address |
| lk_perm | input | 3 | Looked-up permissions |
| lk_miss | input | 1 | Lookup missed |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_miss | output | 1 | Access missed |
| rsp_inst | output | 1 | Response belongs to the instruction path |

## Verification
Addresses are sent with translation off under two control words: zero, and one with only bits 0 and 1 set. This separates the enable decode from a plain non-zero test. Kernel accesses to mapped segments 0, 3, 7, 8 and 15 are given base registers with distinct nibbles, so a wrong register, offset or nibble order shows up as a wrong top nibble. The same mapped address is then sent as a user access and as a kernel access with translation off, which separates the user override from the enable override. Lookup traffic with kind codes 2 and 3, stalled lookup and response handshakes, and miss and hit results check the forwarding path, the kind normalisation and the hold rules.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CSEL_CTRL   = 2'd0,
    CSEL_SEGMAP = 2'd1,
    CSEL_BASELO = 2'd2,
    CSEL_BASEHI = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LK_REQ  = 2'd1,
    ST_LK_WAIT = 2'd2,
    ST_RESP    = 2'd3
  } xl_state_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import seg_xlate_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int SEG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [1:0]                  sel,
  input  logic [CFG_W-1:0]            wdata,
  output logic [CFG_W-1:0]            ctrl_q,
  output logic [(1<<SEG_W)-1:0]       segmap_q,
  output logic [((1<<SEG_W)/2)*SEG_W-1:0] base_lo_q,
  output logic [((1<<SEG_W)/2)*SEG_W-1:0] base_hi_q
);
  localparam int SEGS   = 1 << SEG_W;
  localparam int BASE_W = (SEGS / 2) * SEG_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      segmap_q  <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        CSEL_CTRL:   ctrl_q    <= wdata;
        CSEL_SEGMAP: segmap_q  <= wdata[SEGS-1:0];
        CSEL_BASELO: base_lo_q <= wdata[BASE_W-1:0];
        CSEL_BASEHI: base_hi_q <= wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import seg_xlate_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int CFG_W    = 32,
  parameter int SEG_W    = 4,
  parameter int EN_BIT_A = 2,
  parameter int EN_BIT_B = 3
) (
  input  logic [VA_W-1:0]                 vaddr,
  input  logic [1:0]                      kind,
  input  logic                            user,
  input  logic [CFG_W-1:0]                ctrl,
  input  logic [(1<<SEG_W)-1:0]           segmap,
  input  logic [((1<<SEG_W)/2)*SEG_W-1:0] base_lo,
  input  logic [((1<<SEG_W)/2)*SEG_W-1:0] base_hi,
  output logic                            xlate_on,
  output logic                            local_hit,
  output logic [VA_W-1:0]                 local_paddr,
  output logic [1:0]                      kind_n,
  output logic                            inst
);
  localparam int SEGS  = 1 << SEG_W;
  localparam int HALF  = SEGS / 2;
  localparam int OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] nib_tab [SEGS];
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic             direct;

  for (genvar g = 0; g < SEGS; g++) begin : g_nib
    if (g < HALF) begin : g_lo
      assign nib_tab[g] = base_lo[g*SEG_W +: SEG_W];
    end else begin : g_hi
      assign nib_tab[g] = base_hi[(g-HALF)*SEG_W +: SEG_W];
    end
  end

  assign seg      = vaddr[VA_W-1 -: SEG_W];
  assign off      = vaddr[OFF_W-1:0];
  assign xlate_on = ctrl[EN_BIT_A] | ctrl[EN_BIT_B];
  assign direct   = !user && segmap[seg];

  always_comb begin
    local_hit   = !xlate_on || direct;
    local_paddr = xlate_on ? {nib_tab[seg], off} : vaddr;
    inst        = (acc_kind_e'(kind) == ACC_EXEC);
    kind_n      = (acc_kind_e'(kind) == ACC_RSVD) ? ACC_READ : kind;
  end
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_user,
  input  logic              dec_local,
  input  logic [VA_W-1:0]   dec_paddr,
  input  logic [1:0]        dec_kind,
  input  logic              dec_inst,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [VA_W-1:0]   lk_vaddr,
  output logic [1:0]        lk_kind,
  output logic              lk_user,
  output logic              lk_inst,
  input  logic              lk_done,
  input  logic [VA_W-1:0]   lk_paddr,
  input  logic [PERM_W-1:0] lk_perm,
  input  logic              lk_miss,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_miss,
  output logic              rsp_inst
);
  xl_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lk_vaddr  <= '0;
      lk_kind   <= '0;
      lk_user   <= 1'b0;
      lk_inst   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_miss  <= 1'b0;
      rsp_inst  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (dec_local) begin
            rsp_paddr <= dec_paddr;
            rsp_perm  <= PERM_ALL;
            rsp_miss  <= 1'b0;
            rsp_inst  <= dec_inst;
            state_q   <= ST_RESP;
          end else begin
            lk_vaddr <= req_vaddr;
            lk_kind  <= dec_kind;
            lk_user  <= req_user;
            lk_inst  <= dec_inst;
            state_q  <= ST_LK_REQ;
          end
        end
        ST_LK_REQ: if (lk_ready) state_q <= ST_LK_WAIT;
        ST_LK_WAIT: if (lk_done) begin
          rsp_paddr <= lk_paddr;
          rsp_perm  <= lk_perm;
          rsp_miss  <= lk_miss;
          rsp_inst  <= lk_inst;
          state_q   <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign lk_valid  = (state_q == ST_LK_REQ);
  assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int CFG_W = 32,
  parameter int SEG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [VA_W-1:0]   lk_vaddr,
  output logic [1:0]        lk_kind,
  output logic              lk_user,
  output logic              lk_inst,
  input  logic              lk_done,
  input  logic [VA_W-1:0]   lk_paddr,
  input  logic [PERM_W-1:0] lk_perm,
  input  logic              lk_miss,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_miss,
  output logic              rsp_inst
);
  localparam int SEGS   = 1 << SEG_W;
  localparam int BASE_W = (SEGS / 2) * SEG_W;

  logic [CFG_W-1:0]  ctrl_q;
  logic [SEGS-1:0]   segmap_q;
  logic [BASE_W-1:0] base_lo_q;
  logic [BASE_W-1:0] base_hi_q;
  logic              xlate_on;
  logic              dec_local;
  logic [VA_W-1:0]   dec_paddr;
  logic [1:0]        dec_kind;
  logic              dec_inst;

  seg_cfg_regs #(.CFG_W(CFG_W), .SEG_W(SEG_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .segmap_q(segmap_q), .base_lo_q(base_lo_q), .base_hi_q(base_hi_q)
  );

  seg_decode #(.VA_W(VA_W), .CFG_W(CFG_W), .SEG_W(SEG_W)) dec_i (
    .vaddr(req_vaddr), .kind(req_kind), .user(req_user), .ctrl(ctrl_q),
    .segmap(segmap_q), .base_lo(base_lo_q), .base_hi(base_hi_q),
    .xlate_on(xlate_on), .local_hit(dec_local), .local_paddr(dec_paddr),
    .kind_n(dec_kind), .inst(dec_inst)
  );

  seg_xlate_ctrl #(.VA_W(VA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
    .dec_local(dec_local), .dec_paddr(dec_paddr), .dec_kind(dec_kind), .dec_inst(dec_inst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_user(lk_user), .lk_inst(lk_inst), .lk_done(lk_done), .lk_paddr(lk_paddr),
    .lk_perm(lk_perm), .lk_miss(lk_miss),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_miss(rsp_miss), .rsp_inst(rsp_inst)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int CFG_W = 32,
  parameter int SEG_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [VA_W-1:0]      req_vaddr,
  input logic                 req_user,
  input logic [CFG_W-1:0]     ctrl_q,
  input logic [(1<<SEG_W)-1:0] segmap_q,
  input logic                 lk_valid,
  input logic                 lk_ready,
  input logic [VA_W-1:0]      lk_vaddr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [VA_W-1:0]      rsp_paddr,
  input logic [2:0]           rsp_perm,
  input logic                 rsp_miss
);
  localparam int OFF_W = VA_W - SEG_W;
  logic on_w, take_w;
  assign on_w   = ctrl_q[2] | ctrl_q[3];
  assign take_w = req_valid && req_ready;

  assert_bypass_ident_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !on_w) |=> (rsp_valid && rsp_paddr == $past(req_vaddr) &&
                           rsp_perm == 3'b111 && !rsp_miss));

  assert_direct_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && on_w && !req_user && segmap_q[req_vaddr[VA_W-1 -: SEG_W]]) |=>
    (rsp_valid && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]) &&
     rsp_perm == 3'b111 && !rsp_miss));

  assert_user_paged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && on_w && req_user) |=> (lk_valid && lk_vaddr == $past(req_vaddr)));

  assert_lk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_vaddr)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_perm) && $stable(rsp_miss)));

  assert_one_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, lk_valid, rsp_valid}));
endmodule

bind seg_xlate_front seg_xlate_chk #(.VA_W(VA_W), .CFG_W(CFG_W), .SEG_W(SEG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_user(req_user), .ctrl_q(ctrl_q), .segmap_q(segmap_q),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_perm(rsp_perm), .rsp_miss(rsp_miss)
);

// File: tb/seg_xlate_front_tb.sv
`timescale 1ns/1ps
module seg_xlate_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready, lk_valid, lk_user, lk_inst, rsp_valid, rsp_miss, rsp_inst;
  logic [31:0] lk_vaddr, rsp_paddr;
  logic [1:0]  lk_kind;
  logic [2:0]  rsp_perm;
  logic        lk_ready = 1'b0, lk_done = 1'b0, lk_miss = 1'b0, rsp_ready = 1'b0;
  logic [31:0] lk_paddr = '0;
  logic [2:0]  lk_perm = '0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate_front dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_user(lk_user), .lk_inst(lk_inst), .lk_done(lk_done), .lk_paddr(lk_paddr),
    .lk_perm(lk_perm), .lk_miss(lk_miss),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_miss(rsp_miss), .rsp_inst(rsp_inst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] va, input logic [1:0] k, input logic u);
    @(negedge clk);
    chk("R9 req_ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u;
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  // checks response already present, stalls it, then takes it
  task automatic take_rsp(input string tag, input logic [31:0] pa, input logic [2:0] pm,
                          input logic ms, input logic in);
    chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " rsp_paddr"}, rsp_paddr, pa);
    chk({tag, " rsp_perm"}, {29'b0, rsp_perm}, {29'b0, pm});
    chk({tag, " rsp_miss"}, {31'b0, rsp_miss}, {31'b0, ms});
    chk({tag, " R8 rsp_inst"}, {31'b0, rsp_inst}, {31'b0, in});
    repeat (2) @(posedge clk);
    #1;
    chk("R9 rsp held", {rsp_paddr[30:0], rsp_valid}, {pa[30:0], 1'b1});
    chk("R9 req_ready low while busy", {31'b0, req_ready}, 32'd0);
    @(negedge clk); rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
    chk("R9 rsp drained", {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic run_local(input string tag, input logic [31:0] va, input logic [1:0] k,
                           input logic [31:0] pa);
    send(va, k, 1'b0);
    take_rsp(tag, pa, 3'b111, 1'b0, k == 2'd2);
  endtask

  task automatic run_paged(input string tag, input logic [31:0] va, input logic [1:0] k,
                           input logic u, input logic [1:0] exp_k, input logic [31:0] pa,
                           input logic [2:0] pm, input logic ms);
    send(va, k, u);
    chk({tag, " R6 lk_valid"}, {31'b0, lk_valid}, 32'd1);
    chk({tag, " R6 lk_vaddr"}, lk_vaddr, va);
    chk({tag, " R8 lk_kind"}, {30'b0, lk_kind}, {30'b0, exp_k});
    chk({tag, " R6 lk_user"}, {31'b0, lk_user}, {31'b0, u});
    chk({tag, " R8 lk_inst"}, {31'b0, lk_inst}, {31'b0, k == 2'd2});
    chk({tag, " R5 no early rsp"}, {31'b0, rsp_valid}, 32'd0);
    @(posedge clk); #1;
    chk({tag, " R6 lk held"}, {31'b0, lk_valid}, 32'd1);
    @(negedge clk); lk_ready = 1'b1;
    @(posedge clk); #1 lk_ready = 1'b0;
    chk({tag, " R6 lk dropped"}, {31'b0, lk_valid}, 32'd0);
    @(negedge clk); lk_done = 1'b1; lk_paddr = pa; lk_perm = pm; lk_miss = ms;
    @(posedge clk); #1 lk_done = 1'b0; lk_paddr = '0; lk_perm = '0; lk_miss = 1'b0;
    take_rsp({tag, " R7"}, pa, pm, ms, k == 2'd2);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 lk_valid", {31'b0, lk_valid}, 32'd0);
    run_local("R1 ctrl zero passthrough", 32'h3ABC_DEF0, 2'd0, 32'h3ABC_DEF0);
  endtask

  task automatic t_off();
    run_local("R2 off ctrl=0", 32'h89AB_CDEF, 2'd1, 32'h89AB_CDEF);
    wr_cfg(2'd0, 32'h0000_0003);
    run_local("R2 off ctrl=3", 32'h1234_5678, 2'd2, 32'h1234_5678);
  endtask

  task automatic t_unmapped();
    wr_cfg(2'd0, 32'h0000_0004);
    run_paged("R10 R1 segmap zero", 32'h3000_1000, 2'd0, 1'b0, 2'd0,
              32'h0011_2000, 3'b001, 1'b0);
  endtask

  task automatic t_direct();
    wr_cfg(2'd2, 32'h8765_4321);
    wr_cfg(2'd3, 32'hFEDC_BA9A);
    wr_cfg(2'd1, 32'h0000_8189);
    wr_cfg(2'd0, 32'h0000_0008);
    run_local("R3 R4 seg3", 32'h3ABC_DEF0, 2'd0, 32'h4ABC_DEF0);
    run_local("R4 seg0 exec", 32'h0000_0004, 2'd2, 32'h1000_0004);
    run_local("R4 seg7", 32'h7FFF_FFFF, 2'd1, 32'h8FFF_FFFF);
    run_local("R4 seg8", 32'h8123_4567, 2'd1, 32'hA123_4567);
    run_local("R4 R8 seg15 kind3", 32'hF000_0001, 2'd3, 32'hF000_0001);
  endtask

  task automatic t_paged();
    run_paged("R5 user mapped", 32'h3ABC_DEF0, 2'd1, 1'b1, 2'd1, 32'h0055_5000, 3'b011, 1'b0);
    run_paged("R8 exec unmapped miss", 32'h5000_0000, 2'd2, 1'b0, 2'd2, 32'h0, 3'b000, 1'b1);
    run_paged("R8 kind3 as read", 32'h2000_0000, 2'd3, 1'b0, 2'd0, 32'hC0DE_0000, 3'b101, 1'b0);
  endtask

  task automatic t_off_again();
    wr_cfg(2'd0, 32'h0000_0000);
    run_local("R2 off overrides map", 32'h3ABC_DEF0, 2'd0, 32'h3ABC_DEF0);
  endtask

  initial begin
    t_reset();
    t_off();
    t_unmapped();
    t_direct();
    t_paged();
    t_off_again();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule